// File: doc/BRIEF.md
# I2C Prescaler and SCL Clock Generator

This block turns a fast peripheral clock into the slower timing base of an I2C controller. An 8-bit prescaler divides the input clock into a module tick: a one-cycle enable pulse every (prescaler + 1) input clocks. A phase generator counts these ticks to form the controller SCL waveform. The low phase and the high phase each have their own programmable count. The hardware adds a fixed offset d to each phase, and d depends on the prescaler setting.

Software programs four write-only registers through a simple write port. The block drives SCL as open drain: it asserts a drive-low output and reads the wired line back through a two-flop synchronizer. This lets it take part in clock synchronization. If another device holds SCL low, the high phase waits. If another device pulls SCL low during the high phase, a new low phase begins at once.

A new prescaler value is accepted only while the run bit is clear, and it is applied only on the 0-to-1 edge of the run bit. The offset d is fixed at that same moment. Software must keep the module tick rate in the 6.7 MHz to 13.3 MHz band; the hardware does not check this.

Top module: `scl_clock_gen`

## Requirements
- R1: With the run bit set, modTick is high for one cycle in every (P + 1) input clocks, where P is the latched prescaler value.
- R2: While the run bit is clear, modTick stays low and the prescaler count is held at zero. After the run bit is set, the first modTick is registered P + 1 clocks after the write edge.
- R3: A prescaler write while the run bit is set changes neither the tick period nor the offset d.
- R4: A prescaler value written while the run bit is clear takes effect only when the run bit next goes from 0 to 1.
- R5: The SCL low phase lasts (L + d) module ticks, which is (L + d)(P + 1) input clocks. L is the low count, and d is 7 for P = 0, 6 for P = 1 and 5 for P greater than 1.
- R6: The SCL high phase lasts (H + d) module ticks, counted from the moment the synchronized line reads high. H is the high count.
- R7: While the released line is still held low by another device, the high-phase count does not advance and sclDriveLow stays low.
- R8: If the synchronized line reads low during the high phase, sclDriveLow rises on the third clock edge after the line fell, and a full (L + d)-tick low phase follows.
- R9: sclDriveLow is low out of reset, and it goes low one edge after either the run bit or the SCL enable bit is cleared.
- R10: The register map is selected by wrAddr and written only when wrEn is high. Address 0 is control: bit 0 is the run bit and bit 1 is the SCL enable bit. Address 1 is the prescaler, in bits 7:0. Address 2 is the low count and address 3 is the high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | CNT_W | Register write data |
| sclIn | input | 1 | Sampled wired SCL line |
| modTick | output | 1 | Module clock enable pulse |
| sclDriveLow | output | 1 | Open-drain SCL pull-down request |

## Verification
The timing is counted from the write edge. The first tick is due P + 1 edges after the run write, and each later tick follows P + 1 clocks after the one before it. The SCL drive changes on the edge after the tick that ends a phase. A pull-low during the high phase shows on the drive after three edges, and a disable shows on the drive after one edge. The bench samples every output on falling edges. It measures phase lengths by counting modTick samples while the drive is in one state. It releases external pull-downs just after a tick, so the synchronizer latency never hides or adds a tick.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  // register select codes
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PSC  = 2'd1;
  localparam logic [1:0] ADDR_LOW  = 2'd2;
  localparam logic [1:0] ADDR_HIGH = 2'd3;

  // phase generator states
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic countEn;
  } phStrobe_t;

endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs
  import sclgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             runEn,
  output logic             genEn,
  output logic [PSC_W-1:0] pscLive,
  output logic [CNT_W-1:0] lowCnt,
  output logic [CNT_W-1:0] highCnt,
  output logic [2:0]       dOff
);

  logic [PSC_W-1:0] pscStage;
  logic [2:0]       dNext;
  logic             runRise;
  logic             unusedData;

  assign unusedData = ^wrData;

  // offset chosen from the staged prescaler value
  always_comb begin
    if (pscStage == '0)
      dNext = 3'd7;
    else if (pscStage == PSC_W'(1))
      dNext = 3'd6;
    else
      dNext = 3'd5;
  end

  assign runRise = wrEn && (wrAddr == ADDR_CTRL) && wrData[0] && !runEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      genEn    <= 1'b0;
      pscStage <= '0;
      lowCnt   <= '0;
      highCnt  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          runEn <= wrData[0];
          genEn <= wrData[1];
        end
        ADDR_PSC: begin
          if (!runEn) pscStage <= wrData[PSC_W-1:0];
        end
        ADDR_LOW:  lowCnt  <= wrData;
        default:   highCnt <= wrData;
      endcase
    end
  end

  // divide ratio and offset are fixed on the run edge only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscLive <= '0;
      dOff    <= 3'd7;
    end else if (runRise) begin
      pscLive <= pscStage;
      dOff    <= dNext;
    end
  end

  // R3
  pscHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> ($stable(pscLive) && $stable(dOff)));

endmodule

// File: rtl/sclgen_dp.sv
module sclgen_dp
  import sclgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [PSC_W-1:0] pscLive,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic [2:0]       dOff,
  input  logic             sclIn,
  input  phStrobe_t        strobe,
  output logic             modTick,
  output logic             phaseDone,
  output logic             sclSync
);

  localparam int PH_W = CNT_W + 1;

  logic [PSC_W-1:0] psCnt;
  logic [1:0]       syncPipe;
  logic [PH_W-1:0]  phRem;
  logic [PH_W-1:0]  lowLoad;
  logic [PH_W-1:0]  highLoad;

  // prescaler: one tick per (pscLive + 1) input clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt   <= '0;
      modTick <= 1'b0;
    end else if (!runEn) begin
      psCnt   <= '0;
      modTick <= 1'b0;
    end else if (psCnt == pscLive) begin
      psCnt   <= '0;
      modTick <= 1'b1;
    end else begin
      psCnt   <= psCnt + 1'b1;
      modTick <= 1'b0;
    end
  end

  // line synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= 2'b11;
    else       syncPipe <= {syncPipe[0], sclIn};
  end
  assign sclSync = syncPipe[1];

  assign lowLoad  = {1'b0, lowCnt}  + PH_W'(dOff);
  assign highLoad = {1'b0, highCnt} + PH_W'(dOff);

  // phase length down-counter in module ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phRem <= '0;
    else if (strobe.loadLow)
      phRem <= lowLoad;
    else if (strobe.loadHigh)
      phRem <= highLoad;
    else if (strobe.countEn && modTick && (phRem != '0))
      phRem <= phRem - 1'b1;
  end

  assign phaseDone = strobe.countEn && modTick && (phRem == PH_W'(1));

  // R2
  noTick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !modTick);

  // R1
  psBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |-> (psCnt <= pscLive));

  // R5
  phLive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn |-> (phRem != '0));

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      genEn,
  input  logic      phaseDone,
  input  logic      sclSync,
  output phStrobe_t strobe,
  output logic      sclDriveLow
);

  phase_e state, stateNext;
  logic   active;

  assign active = runEn && genEn;

  always_comb begin
    stateNext       = state;
    strobe.loadLow  = 1'b0;
    strobe.loadHigh = 1'b0;
    if (!active) begin
      stateNext = PH_OFF;
    end else begin
      case (state)
        PH_OFF: begin
          stateNext      = PH_LOW;
          strobe.loadLow = 1'b1;
        end
        PH_LOW: begin
          if (phaseDone) stateNext = PH_WAIT;
        end
        PH_WAIT: begin
          if (sclSync) begin
            stateNext       = PH_HIGH;
            strobe.loadHigh = 1'b1;
          end
        end
        default: begin
          if (!sclSync || phaseDone) begin
            stateNext      = PH_LOW;
            strobe.loadLow = 1'b1;
          end
        end
      endcase
    end
  end

  assign strobe.countEn = (state == PH_LOW) || (state == PH_HIGH);
  assign sclDriveLow    = (state == PH_LOW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_OFF;
    else       state <= stateNext;
  end

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !sclDriveLow);

  // R7
  waitHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && state == PH_WAIT && !sclSync) |=> (!sclDriveLow && state != PH_HIGH));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && state == PH_HIGH && !sclSync) |=> sclDriveLow);

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             sclIn,
  output logic             modTick,
  output logic             sclDriveLow
);

  logic             runEn;
  logic             genEn;
  logic [PSC_W-1:0] pscLive;
  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] highCnt;
  logic [2:0]       dOff;
  logic             phaseDone;
  logic             sclSync;
  phStrobe_t        strobe;

  sclgen_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W)) regsI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .runEn(runEn), .genEn(genEn), .pscLive(pscLive), .lowCnt(lowCnt),
    .highCnt(highCnt), .dOff(dOff)
  );

  sclgen_dp #(.PSC_W(PSC_W), .CNT_W(CNT_W)) dpI (
    .clk(clk), .rstN(rstN), .runEn(runEn), .pscLive(pscLive),
    .lowCnt(lowCnt), .highCnt(highCnt), .dOff(dOff), .sclIn(sclIn),
    .strobe(strobe), .modTick(modTick), .phaseDone(phaseDone),
    .sclSync(sclSync)
  );

  sclgen_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .runEn(runEn), .genEn(genEn),
    .phaseDone(phaseDone), .sclSync(sclSync), .strobe(strobe),
    .sclDriveLow(sclDriveLow)
  );

endmodule

// File: tb/scl_clock_gen_test.sv
module scl_clock_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [1:0]       wrAddr = 2'd0;
  logic [CNT_W-1:0] wrData = '0;
  logic             extLow = 1'b0;
  logic             sclIn;
  logic             modTick;
  logic             sclDriveLow;
  int               total = 0;
  int               bad = 0;
  bit               finished = 1'b0;

  assign sclIn = ~(sclDriveLow | extLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_clock_gen #(.PSC_W(8), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sclIn(sclIn), .modTick(modTick), .sclDriveLow(sclDriveLow)
  );

  function automatic int dFor(input int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d[CNT_W-1:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickGap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!modTick && n < 5000);
  endtask

  task automatic lowPhase(output int ticks, output int clocks);
    int g = 0;
    while (sclDriveLow && g < 20000) begin @(negedge clk); g++; end
    while (!sclDriveLow && g < 20000) begin @(negedge clk); g++; end
    ticks = 0; clocks = 0;
    while (sclDriveLow && clocks < 20000) begin
      if (modTick) ticks++;
      clocks++;
      @(negedge clk);
    end
  endtask

  task automatic highPhase(output int ticks);
    int g = 0;
    while (!sclDriveLow && g < 20000) begin @(negedge clk); g++; end
    while (sclDriveLow && g < 20000) begin @(negedge clk); g++; end
    ticks = 0;
    while (!sclDriveLow && g < 40000) begin
      if (modTick && sclIn) ticks++;
      g++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int p, input int l, input int h);
    wr(2'd0, 0);
    wr(2'd1, p);
    wr(2'd2, l);
    wr(2'd3, h);
    wr(2'd0, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, t, c, cnt;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R9 R2: reset state
    chk("R9 reset drive", sclDriveLow, 0);
    chk("R2 reset tick", modTick, 0);
    rstN = 1'b1;

    // R2: idle, no ticks
    cnt = 0;
    repeat (30) begin @(negedge clk); if (modTick) cnt++; end
    chk("R2 no tick while stopped", cnt, 0);

    // R5: offset for small prescaler values
    for (int p = 0; p < 3; p++) begin
      setup(p, 3, 4);
      lowPhase(t, c);
      chk("R5 low ticks", t, 3 + dFor(p));
      chk("R5 low clocks", c, (3 + dFor(p)) * (p + 1));
    end

    // random configurations
    for (int i = 0; i < 6; i++) begin
      int p, l, h;
      p = $urandom_range(9, 3);
      l = $urandom_range(15, 0);
      h = $urandom_range(15, 0);
      setup(p, l, h);
      tickGap(n);
      chk("R2 first tick delay", n, p + 1);
      tickGap(n);
      chk("R1 tick period", n, p + 1);
      lowPhase(t, c);
      chk("R5 low ticks", t, l + dFor(p));
      chk("R5 low clocks", c, (l + dFor(p)) * (p + 1));
      highPhase(t);
      chk("R6 high ticks", t, h + dFor(p));
    end

    // R3: prescaler write while running is ignored
    setup(1, 4, 4);
    wr(2'd1, 7);
    tickGap(n);
    tickGap(n);
    chk("R3 period kept", n, 2);
    lowPhase(t, c);
    chk("R3 offset kept", t, 4 + 6);

    // R4 R10: staged value, stray data without strobe
    wr(2'd0, 0);
    wr(2'd1, 6);
    cnt = 0;
    repeat (30) begin @(negedge clk); if (modTick) cnt++; end
    chk("R2 stopped after clear", cnt, 0);
    @(negedge clk);
    wrAddr = 2'd1; wrData = 12'd2;
    @(negedge clk);
    wr(2'd0, 1);
    tickGap(n);
    chk("R4 first tick new value", n, 7);
    tickGap(n);
    chk("R10 period after stray data", n, 7);

    // R7: clock stretch by another device
    setup(4, 2, 3);
    while (!sclDriveLow) @(negedge clk);
    extLow = 1'b1;
    while (sclDriveLow) @(negedge clk);
    cnt = 0;
    repeat (25) begin @(negedge clk); if (sclDriveLow) cnt++; end
    chk("R7 no drive while held", cnt, 0);
    while (!modTick) @(negedge clk);
    extLow = 1'b0;
    @(negedge clk);
    t = 0;
    n = 0;
    while (!sclDriveLow && n < 5000) begin
      if (modTick && sclIn) t++;
      n++;
      @(negedge clk);
    end
    chk("R7 high after stretch", t, 3 + 5);

    // R8: pull-low during high restarts low phase
    while (sclDriveLow) @(negedge clk);
    cnt = 0;
    while (cnt < 2) begin @(negedge clk); if (modTick) cnt++; end
    extLow = 1'b1;
    n = 0;
    while (!sclDriveLow && n < 20) begin
      @(negedge clk); n++;
      if (n == 2) extLow = 1'b0;
    end
    extLow = 1'b0;
    chk("R8 drive latency", n, 3);
    t = 0; c = 0;
    while (sclDriveLow && c < 5000) begin
      if (modTick) t++;
      c++;
      @(negedge clk);
    end
    chk("R8 restarted low ticks", t, 2 + 5);

    // R9: disable paths
    wr(2'd0, 1);
    @(negedge clk);
    chk("R9 gen off release", sclDriveLow, 0);
    cnt = 0; t = 0;
    repeat (20) begin
      @(negedge clk);
      if (sclDriveLow) cnt++;
      if (modTick) t++;
    end
    chk("R9 stays released", cnt, 0);
    chk("R1 ticks with gen off", t, 4);
    wr(2'd0, 3);
    @(negedge clk);
    chk("R9 restart drives low", sclDriveLow, 1);
    wr(2'd0, 2);
    @(negedge clk);
    chk("R9 run off release", sclDriveLow, 0);
    t = 0;
    repeat (20) begin @(negedge clk); if (modTick) t++; end
    chk("R2 no tick run off", t, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule